// File: doc/BRIEF.md
# Banked Cartridge Address Decoder

This block sits between the CPU of a small 8-bit handheld console and its cartridge and I/O space. It splits the 16-bit CPU address space into four targets and sends each access to exactly one of them. The targets are a fixed ROM bank, a ROM window whose bank can be switched, an external RAM window whose bank can also be switched, and a short run of memory-mapped I/O registers. ROM and RAM storage sit outside the block. The block drives their widened addresses and enables, and it picks which returned byte reaches the CPU.

A write into the ROM half of the address space never reaches storage. It is treated as a command that loads one of three control registers. Writes to 0x0000–0x1FFF unlock or lock the external RAM. Writes to 0x2000–0x3FFF pick the ROM bank for the window. Writes to 0x4000–0x5FFF pick the RAM bank. A new setting applies to accesses from the next clock cycle on.

Decode and steering are purely combinational. An access is one cycle with `cpu_rd` or `cpu_wr` high. When both strobes are high in the same cycle, the access is handled as a write.

Top module: `cart_map_decoder`

## Requirements
- R1: A read in 0x0000–0x3FFF asserts `rom_rd_en`, drives `rom_addr = {5'b0, addr[13:0]}` and returns `rom_rdata` on `cpu_rdata`.
- R2: A read in 0x4000–0x7FFF asserts `rom_rd_en`, drives `rom_addr = {rom_bank, addr[13:0]}` with the current 5-bit ROM bank, and returns `rom_rdata`.
- R3: A write anywhere in 0x0000–0x7FFF asserts none of `rom_rd_en`, `ram_rd_en`, `ram_wr_en` and `io_strobe`. Its effect on the control registers is visible from the following cycle.
- R4: A write in 0x2000–0x3FFF loads data bits [4:0] into the ROM bank. A value of 0 loads bank 1 instead.
- R5: A write in 0x0000–0x1FFF unlocks the external RAM when data bits [3:0] equal 0xA, and locks it for any other value.
- R6: A write in 0x4000–0x5FFF loads data bits [1:0] into the RAM bank. A write in 0x6000–0x7FFF changes no setting.
- R7: When the RAM is unlocked, an access in 0xA000–0xBFFF drives `ram_addr = {ram_bank, addr[12:0]}`. A read asserts `ram_rd_en` and returns `ram_rdata`. A write asserts `ram_wr_en`.
- R8: When the RAM is locked, an access in 0xA000–0xBFFF asserts no RAM enable, and a read returns 0xFF.
- R9: Every read or write in 0xFF00–0xFF4B asserts `io_strobe` for that cycle, with `io_reg = addr[7:0]` and `io_write` high for writes. This holds even when the same value is written again. A read returns `io_rdata`.
- R10: Any other address (0x8000–0x9FFF, 0xC000–0xFEFF, 0xFF4C–0xFFFF) asserts no enable or strobe, and a read returns 0xFF. At most one target is enabled in any cycle.
- R11: After reset the ROM bank is 1, the RAM bank is 0 and the RAM is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read access this cycle |
| cpu_wr | input | 1 | Write access this cycle |
| cpu_rdata | output | 8 | Byte returned to the CPU (0xFF when nothing answers) |
| rom_rdata | input | 8 | Byte from ROM storage |
| ram_rdata | input | 8 | Byte from RAM storage |
| io_rdata | input | 8 | Byte from the selected I/O register |
| rom_addr | output | 19 | Widened ROM address |
| rom_rd_en | output | 1 | ROM read enable |
| ram_addr | output | 15 | Widened RAM address |
| ram_rd_en | output | 1 | RAM read enable |
| ram_wr_en | output | 1 | RAM write enable |
| io_strobe | output | 1 | One-cycle I/O access strobe |
| io_write | output | 1 | High when the I/O access is a write |
| io_reg | output | 8 | Low address byte of the I/O access |

## Verification
The block holds only three registers: the ROM bank, the RAM bank and the RAM lock. Any of them going wrong shows up at the ports on the first later access that depends on it. A bad ROM bank appears in the upper bits of `rom_addr` on the next window read. A bad RAM bank appears in the upper bits of `ram_addr` on the next RAM access. A bad lock appears as a missing enable, or a spurious one, together with a 0xFF or non-0xFF read on the next RAM-window access. Decode faults are visible in the same cycle as the access. The bench therefore compares every output against a behavioural model on every cycle, so a fault is reported at the first access that can expose it.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

  localparam int ROM_OFS_W = 14;
  localparam int RAM_OFS_W = 13;

  typedef enum logic [2:0] {
    RG_ROM_FIXED,
    RG_ROM_SWITCH,
    RG_RAM_WIN,
    RG_IO,
    RG_NONE
  } region_e;

  // Control command selected by a write into the ROM half (address bits 14:13).
  typedef enum logic [1:0] {
    CT_RAM_LOCK = 2'b00,
    CT_ROM_BANK = 2'b01,
    CT_RAM_BANK = 2'b10,
    CT_NONE     = 2'b11
  } ctl_e;

  function automatic region_e classify(input logic [15:0] a, input logic [7:0] io_last);
    region_e r;
    if (a[15:14] == 2'b00)                          r = RG_ROM_FIXED;
    else if (a[15:14] == 2'b01)                     r = RG_ROM_SWITCH;
    else if (a[15:13] == 3'b101)                    r = RG_RAM_WIN;
    else if (a[15:8] == 8'hFF && a[7:0] <= io_last) r = RG_IO;
    else                                            r = RG_NONE;
    return r;
  endfunction

  function automatic ctl_e ctl_kind(input logic [15:0] a);
    return ctl_e'(a[14:13]);
  endfunction

  function automatic logic unlock_code(input logic [7:0] d);
    return d[3:0] == 4'hA;
  endfunction

endpackage

// File: rtl/cart_region_decode.sv
module cart_region_decode
  import cart_map_pkg::*;
#(
  parameter logic [7:0] IO_LAST = 8'h4B
) (
  input  logic [15:0] addr,
  input  logic        rd,
  input  logic        wr,
  output region_e     region,
  output logic        rd_act,
  output logic        wr_act,
  output logic        ctl_wr
);
  // A cycle with both strobes is taken as a write.
  assign rd_act = rd & ~wr;
  assign wr_act = wr;
  assign region = classify(addr, IO_LAST);
  assign ctl_wr = wr_act & ((region == RG_ROM_FIXED) | (region == RG_ROM_SWITCH));
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_map_pkg::*;
#(
  parameter int ROM_BANK_W = 5,
  parameter int RAM_BANK_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_wr,
  input  logic [15:0]           addr,
  input  logic [7:0]            wdata,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ram_on
);
  localparam logic [ROM_BANK_W-1:0] BANK_ONE = ROM_BANK_W'(1);

  ctl_e                  kind;
  logic [ROM_BANK_W-1:0] rom_sel;

  assign kind    = ctl_kind(addr);
  assign rom_sel = wdata[ROM_BANK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_bank <= BANK_ONE;
      ram_bank <= '0;
      ram_on   <= 1'b0;
    end else if (ctl_wr) begin
      case (kind)
        CT_RAM_LOCK: ram_on   <= unlock_code(wdata);
        CT_ROM_BANK: rom_bank <= (rom_sel == '0) ? BANK_ONE : rom_sel;
        CT_RAM_BANK: ram_bank <= wdata[RAM_BANK_W-1:0];
        default:     ;
      endcase
    end
  end

  assert_zero_bank_remap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && addr[14:13] == 2'b01 && wdata[ROM_BANK_W-1:0] == '0) |=> (rom_bank == BANK_ONE));

  assert_lock_follows_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && addr[14:13] == 2'b00) |=> (ram_on == ($past(wdata[3:0]) == 4'hA)));

  assert_dead_range_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && addr[14:13] == 2'b11) |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_on)));
endmodule

// File: rtl/cart_addr_steer.sv
module cart_addr_steer
  import cart_map_pkg::*;
#(
  parameter int ROM_BANK_W = 5,
  parameter int RAM_BANK_W = 2,
  localparam int ROM_AW = ROM_BANK_W + ROM_OFS_W,
  localparam int RAM_AW = RAM_BANK_W + RAM_OFS_W
) (
  input  region_e               region,
  input  logic                  rd_act,
  input  logic                  wr_act,
  input  logic [15:0]           addr,
  input  logic [ROM_BANK_W-1:0] rom_bank,
  input  logic [RAM_BANK_W-1:0] ram_bank,
  input  logic                  ram_on,
  input  logic [7:0]            rom_rdata,
  input  logic [7:0]            ram_rdata,
  input  logic [7:0]            io_rdata,
  output logic [ROM_AW-1:0]     rom_addr,
  output logic                  rom_rd_en,
  output logic [RAM_AW-1:0]     ram_addr,
  output logic                  ram_rd_en,
  output logic                  ram_wr_en,
  output logic                  io_strobe,
  output logic                  io_write,
  output logic [7:0]            io_reg,
  output logic [7:0]            cpu_rdata
);
  logic rom_hit, ram_hit;

  assign rom_hit  = (region == RG_ROM_FIXED) | (region == RG_ROM_SWITCH);
  assign ram_hit  = (region == RG_RAM_WIN) & ram_on;

  assign rom_addr = (region == RG_ROM_SWITCH) ? {rom_bank, addr[ROM_OFS_W-1:0]}
                                              : {{ROM_BANK_W{1'b0}}, addr[ROM_OFS_W-1:0]};
  assign ram_addr = {ram_bank, addr[RAM_OFS_W-1:0]};

  assign rom_rd_en = rom_hit & rd_act;
  assign ram_rd_en = ram_hit & rd_act;
  assign ram_wr_en = ram_hit & wr_act;
  assign io_strobe = (region == RG_IO) & (rd_act | wr_act);
  assign io_write  = wr_act;
  assign io_reg    = addr[7:0];

  always_comb begin
    cpu_rdata = 8'hFF;
    if (rom_rd_en)                            cpu_rdata = rom_rdata;
    else if (ram_rd_en)                       cpu_rdata = ram_rdata;
    else if (io_strobe && rd_act)             cpu_rdata = io_rdata;
  end
endmodule

// File: rtl/cart_map_decoder.sv
module cart_map_decoder
  import cart_map_pkg::*;
#(
  parameter int         ROM_BANK_W = 5,
  parameter int         RAM_BANK_W = 2,
  parameter logic [7:0] IO_LAST    = 8'h4B,
  localparam int ROM_AW = ROM_BANK_W + ROM_OFS_W,
  localparam int RAM_AW = RAM_BANK_W + RAM_OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [7:0]        cpu_rdata,
  input  logic [7:0]        rom_rdata,
  input  logic [7:0]        ram_rdata,
  input  logic [7:0]        io_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_rd_en,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_rd_en,
  output logic              ram_wr_en,
  output logic              io_strobe,
  output logic              io_write,
  output logic [7:0]        io_reg
);
  region_e               region;
  logic                  rd_act, wr_act, ctl_wr;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;
  logic                  ram_on;

  cart_region_decode #(.IO_LAST(IO_LAST)) u_decode (
    .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr),
    .region(region), .rd_act(rd_act), .wr_act(wr_act), .ctl_wr(ctl_wr)
  );

  cart_bank_regs #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .addr(cpu_addr), .wdata(cpu_wdata),
    .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_on(ram_on)
  );

  cart_addr_steer #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_steer (
    .region(region), .rd_act(rd_act), .wr_act(wr_act), .addr(cpu_addr),
    .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_on(ram_on),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .io_rdata(io_rdata),
    .rom_addr(rom_addr), .rom_rd_en(rom_rd_en), .ram_addr(ram_addr),
    .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en), .io_strobe(io_strobe),
    .io_write(io_write), .io_reg(io_reg), .cpu_rdata(cpu_rdata)
  );

  assert_fixed_bank_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr && cpu_addr[15:14] == 2'b00) |-> (rom_rd_en && rom_addr[ROM_AW-1:ROM_OFS_W] == '0));

  assert_window_never_bank0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr && cpu_addr[15:14] == 2'b01) |-> (rom_rd_en && rom_addr[ROM_AW-1:ROM_OFS_W] != '0));

  assert_rom_write_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_addr[15]) |-> !(rom_rd_en || ram_rd_en || ram_wr_en || io_strobe));

  assert_locked_ram_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_on |-> !(ram_rd_en || ram_wr_en));

  assert_io_strobe_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    io_strobe |-> ((cpu_rd || cpu_wr) && cpu_addr[15:8] == 8'hFF && cpu_addr[7:0] <= IO_LAST));

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_rd_en, ram_rd_en | ram_wr_en, io_strobe}));

  assert_reset_state_R11: assert property (@(posedge clk)
    !rst_n |=> (rom_bank == ROM_BANK_W'(1) && ram_bank == '0 && !ram_on));
endmodule

// File: tb/cart_map_decoder_test.sv
module cart_map_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata, rom_rdata = '0, ram_rdata = '0, io_rdata = '0;
  logic [18:0] rom_addr;
  logic [14:0] ram_addr;
  logic        rom_rd_en, ram_rd_en, ram_wr_en, io_strobe, io_write;
  logic [7:0]  io_reg;

  int vectors = 0, miscompares = 0;
  int m_rom_bank = 1, m_ram_bank = 0;
  bit m_ram_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_map_decoder uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .io_rdata(io_rdata),
    .rom_addr(rom_addr), .rom_rd_en(rom_rd_en), .ram_addr(ram_addr),
    .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en), .io_strobe(io_strobe),
    .io_write(io_write), .io_reg(io_reg)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp, inout bit bad);
    if (act != exp) begin
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      bad = 1'b1;
    end
  endtask

  // One access cycle: drive at the falling edge, compare after settling, then advance the model.
  task automatic apply(input bit rd, input bit wr, input logic [15:0] a, input logic [7:0] d, input string tag);
    string t;
    bit bad = 1'b0;
    int e_rom_en = 0, e_ram_rd = 0, e_ram_wr = 0, e_io = 0, e_rdata = 'hFF;
    int e_rom_addr = 0, e_ram_addr;
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    rom_rdata = 8'($urandom); ram_rdata = 8'($urandom); io_rdata = 8'($urandom);
    #1;
    e_ram_addr = m_ram_bank * 8192 + int'(a[12:0]);
    if (a < 16'h8000) begin
      if (wr) t = (a[14:13] == 2'b00) ? "R5" : (a[14:13] == 2'b01) ? "R4" : "R6";
      else t = (a < 16'h4000) ? "R1" : "R2";
      if (rd && !wr) begin
        e_rom_en = 1; e_rdata = rom_rdata;
        e_rom_addr = ((a < 16'h4000) ? 0 : m_rom_bank) * 16384 + int'(a[13:0]);
      end
      if (wr) t = {t, "/R3"};
    end else if (a >= 16'hA000 && a < 16'hC000) begin
      t = m_ram_on ? "R7" : "R8";
      if (m_ram_on) begin
        e_ram_rd = (rd && !wr) ? 1 : 0;
        e_ram_wr = wr ? 1 : 0;
        if (rd && !wr) e_rdata = ram_rdata;
      end
    end else if (a >= 16'hFF00 && a <= 16'hFF4B) begin
      t = "R9";
      e_io = (rd || wr) ? 1 : 0;
      if (rd && !wr) e_rdata = io_rdata;
    end else t = "R10";
    if (!rd && !wr) t = "R10";
    if (tag != "") t = tag;
    cmp(t, "rom_rd_en", int'(rom_rd_en), e_rom_en, bad);
    cmp(t, "ram_rd_en", int'(ram_rd_en), e_ram_rd, bad);
    cmp(t, "ram_wr_en", int'(ram_wr_en), e_ram_wr, bad);
    cmp(t, "io_strobe", int'(io_strobe), e_io, bad);
    if (e_rom_en != 0) cmp(t, "rom_addr", int'(rom_addr), e_rom_addr, bad);
    if (e_ram_rd != 0 || e_ram_wr != 0) cmp(t, "ram_addr", int'(ram_addr), e_ram_addr, bad);
    if (e_io != 0) begin
      cmp(t, "io_reg", int'(io_reg), int'(a[7:0]), bad);
      cmp(t, "io_write", int'(io_write), wr ? 1 : 0, bad);
    end
    if (rd) cmp(t, "cpu_rdata", int'(cpu_rdata), e_rdata, bad);
    vectors++;
    if (bad) miscompares++;
    if (wr && a < 16'h8000) begin
      case (a[14:13])
        2'b00: m_ram_on = (d[3:0] == 4'hA);
        2'b01: m_rom_bank = (d[4:0] == 5'd0) ? 1 : int'(d[4:0]);
        2'b10: m_ram_bank = int'(d[1:0]);
        default: ;
      endcase
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R11: reset state seen through the ports
    apply(1, 0, 16'h4567, 8'h00, "R11");
    apply(1, 0, 16'hA010, 8'h00, "R11");
    apply(1, 0, 16'h0123, 8'h00, "R1");
    apply(1, 0, 16'h3FFF, 8'h00, "R1");
    apply(0, 1, 16'h2100, 8'h00, "R3");
    apply(1, 0, 16'h4000, 8'h00, "R4");
    apply(0, 1, 16'h2000, 8'h13, "R3");
    apply(1, 0, 16'h7FFF, 8'h00, "R2");
    apply(0, 1, 16'h3ABC, 8'hE7, "R4");
    apply(1, 0, 16'h5555, 8'h00, "R4");
    apply(0, 1, 16'hA123, 8'h77, "R8");
    apply(0, 1, 16'h0000, 8'h3A, "R5");
    apply(0, 1, 16'hA123, 8'h77, "R7");
    apply(0, 1, 16'h4000, 8'h06, "R6");
    apply(1, 0, 16'hBFFF, 8'h00, "R7");
    apply(0, 1, 16'h6000, 8'h03, "R6");
    apply(1, 0, 16'hA000, 8'h00, "R6");
    apply(0, 1, 16'h1FFF, 8'h0B, "R5");
    apply(1, 0, 16'hA000, 8'h00, "R5");
    apply(0, 1, 16'hFF10, 8'h42, "R9");
    apply(0, 1, 16'hFF10, 8'h42, "R9");
    apply(1, 0, 16'hFF4B, 8'h00, "R9");
    apply(1, 0, 16'hFF4C, 8'h00, "R10");
    apply(1, 0, 16'h8000, 8'h00, "R10");
    apply(1, 0, 16'hC000, 8'h00, "R10");
    apply(0, 1, 16'hFFFF, 8'h99, "R10");
    for (int i = 0; i < 800; i++) begin
      int sel = int'($urandom % 10);
      logic [15:0] a = 16'($urandom);
      logic [7:0]  d = 8'($urandom);
      bit w = 1'($urandom);
      case (sel)
        0, 1: apply(1, 0, {2'b00, a[13:0]}, d, "");
        2, 3: apply(1, 0, {2'b01, a[13:0]}, d, "");
        4:    apply(0, 1, {1'b0, a[14:0]}, ($urandom % 2 == 0) ? {d[7:4], 4'hA} : d, "");
        5, 6: apply(!w, w, {3'b101, a[12:0]}, d, "");
        7:    apply(!w, w, 16'hFF00 + 16'($urandom % 80), d, "");
        8:    apply(!w, w, a, d, "");
        default: apply(0, 0, a, d, "");
      endcase
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule